// File: doc/BRIEF.md
# Cascaded Serial DAC Frame Writer

This controller sits on the host side of a string of identical 12-bit serial DACs. The DACs share one serial clock and one active-low select line that also acts as the load strobe. Each device's shift-register output feeds the data input of the next device, and the output of the last device comes back to the controller. The controller collects one code per device over a valid/ready stream. It then shifts the whole frame out under a single select-low window and raises select, so every device moves its code into its output register at the same moment.

All serial timing is derived from nanosecond minimums and the system clock period, rounded up to whole cycles. These minimums are: data setup before a rising clock, clock high time, clock low time, select-low to first rising clock, last rising clock to select-high, and select-high pulse width. While the frame shifts out, the bit returned from the far end of the chain is captured before each rising clock. The captured bits form the previous frame, which the host can compare against what it last wrote.

Back-pressure rules: `in_ready` is high only while the controller is idle. A word moves only on a cycle with both `in_valid` and `in_ready` high. The host may hold `in_valid` high for any time, and a word offered while `in_ready` is low is neither taken nor lost. It simply waits.

Top module: `dac_chain_ctrl`

## Requirements
- R1: After reset, `sel_n` is 1, `sclk` is 0, `sdata` is 0, `in_ready` is 1, `done` is 0 and `rb_data` is 0.
- R2: A word is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` goes low on the cycle after the `N_DEV`-th word is taken and comes back on the cycle after `done`. Words offered while `in_ready` is low have no effect on any device.
- R3: The first word taken in a frame ends up in the device farthest from the controller. Each word is sent most significant bit first. After the update, device k from the controller (k = 0 nearest) holds word `N_DEV-1-k`.
- R4: `sclk` is 0 on every cycle where `sel_n` is 1, and on the cycle where `sel_n` falls.
- R5: At least the select-to-clock minimum (in cycles) passes between `sel_n` falling and the first rising `sclk`.
- R6: `sdata` is stable for at least the setup minimum before each rising `sclk`, and it does not change while `sclk` is high. Each low phase lasts at least the clock-low minimum.
- R7: At least the clock-to-load minimum passes from the last rising `sclk` to `sel_n` rising. `sel_n` stays high for at least the load pulse minimum before it falls again.
- R8: Each frame has exactly `N_DEV*12` rising `sclk` edges.
- R9: `done` is a one-cycle pulse. It comes exactly select-to-clock + bits*(low phase + high phase) + clock-to-load + load-pulse cycles after the cycle in which the last word was taken. The low phase is the larger of the clock-low and setup minimums.
- R10: When `done` is high, `rb_data` holds the `ret_bit` values sampled before each rising `sclk` of that frame. The first sample is in the most significant bit.
- R11: Each timing minimum in cycles is ceil(ns*1000 / `CLK_PERIOD_PS`), and at least 1. The high phase lasts exactly the clock-high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Code word offered |
| in_ready | output | 1 | Controller can take a word (idle only) |
| in_code | input | CODE_W | Code word, farthest device's word first |
| ret_bit | input | 1 | Serial output of the last device in the chain |
| sclk | output | 1 | Serial clock to all devices |
| sdata | output | 1 | Serial data to the nearest device |
| sel_n | output | 1 | Shared select, active low; rising edge loads all devices |
| done | output | 1 | One-cycle pulse when the update completes |
| rb_data | output | N_DEV*CODE_W | Bits returned from the chain during the last frame |

## Verification
Every serial waveform property is measured at the falling system clock edge. It is measured as the distance in cycles between events on the pins: select fall to first rise, data change to rise, rise to fall, last rise to select rise, and select high run. Because each comparison uses counts taken before the current sample, a phase that ends one cycle early shows up as a short count. `done` is due a fixed number of cycles after the edge that takes the last word, and the bench counts from that edge rather than from any internal state. The returned frame and the device contents are checked on the `done` cycle, because that is when `rb_data` is published. `in_ready` is compared with a behavioural busy flag on every cycle.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL_SETUP,
    ST_CLK_LOW,
    ST_CLK_HIGH,
    ST_TAIL,
    ST_LOAD,
    ST_DONE
  } ctl_state_e;

  // Whole system cycles covering a nanosecond minimum; never fewer than one.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R11: a running phase counts down one per cycle, so its length is exact
  p_exact_countdown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/frame_shreg.sv
module frame_shreg #(
  parameter int unsigned N_DEV  = 2,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CODE_W-1:0] push_word,
  input  logic              shift,
  output logic              msb
);
  localparam int unsigned FRAME_W = N_DEV * CODE_W;

  logic [FRAME_W-1:0] frame_q, frame_push;

  generate
    if (N_DEV == 1) begin : g_single
      assign frame_push = push_word;
    end else begin : g_multi
      assign frame_push = {frame_q[FRAME_W-CODE_W-1:0], push_word};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frame_q <= '0;
    else if (push)  frame_q <= frame_push;
    else if (shift) frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
  end

  assign msb = frame_q[FRAME_W-1];

  // R2: words are only taken while nothing is being shifted out
  p_push_not_during_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && shift));
endmodule

// File: rtl/return_capture.sv
module return_capture #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample,
  input  logic               bit_in,
  input  logic               publish,
  output logic [FRAME_W-1:0] rb_data
);
  logic [FRAME_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      rb_data <= '0;
    end else begin
      if (sample)  cap_q   <= {cap_q[FRAME_W-2:0], bit_in};
      if (publish) rb_data <= cap_q;
    end
  end

  // R10: the published readback changes only on a publish
  p_rb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(publish) |-> $stable(rb_data));
endmodule

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dac_chain_pkg::*;
#(
  parameter int unsigned N_DEV            = 2,
  parameter int unsigned CODE_W           = 12,
  parameter int unsigned CLK_PERIOD_PS    = 5000,
  parameter int unsigned T_SETUP_NS       = 40,
  parameter int unsigned T_CLK_HIGH_NS    = 40,
  parameter int unsigned T_CLK_LOW_NS     = 40,
  parameter int unsigned T_SEL_TO_CLK_NS  = 20,
  parameter int unsigned T_CLK_TO_LOAD_NS = 40,
  parameter int unsigned T_LOAD_PULSE_NS  = 50
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [CODE_W-1:0]          in_code,
  input  logic                       ret_bit,
  output logic                       sclk,
  output logic                       sdata,
  output logic                       sel_n,
  output logic                       done,
  output logic [N_DEV*CODE_W-1:0]    rb_data
);
  localparam int unsigned FRAME_W   = N_DEV * CODE_W;
  localparam int unsigned CYC_SETUP = ns_to_cycles(T_SETUP_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_HIGH  = ns_to_cycles(T_CLK_HIGH_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_LOW   = ns_to_cycles(T_CLK_LOW_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_SEL   = ns_to_cycles(T_SEL_TO_CLK_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_TAIL  = ns_to_cycles(T_CLK_TO_LOAD_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_LOAD  = ns_to_cycles(T_LOAD_PULSE_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_LOWPH = max_u(CYC_LOW, CYC_SETUP);
  localparam int unsigned CYC_MAX   = max_u(max_u(max_u(CYC_HIGH, CYC_LOWPH), max_u(CYC_SEL, CYC_TAIL)), CYC_LOAD);
  localparam int unsigned TMR_W     = $clog2(CYC_MAX + 1);
  localparam int unsigned WC_W      = $clog2(N_DEV + 1);
  localparam int unsigned BL_W      = $clog2(FRAME_W + 1);

  ctl_state_e state_q, state_nx;
  logic [WC_W-1:0]  wcnt_q;
  logic [BL_W-1:0]  bits_q;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_load, tmr_zero;
  logic             accept, last_word, frame_shift, ret_sample, rb_publish;

  assign in_ready    = (state_q == ST_IDLE);
  assign accept      = in_valid && in_ready;
  assign last_word   = accept && (wcnt_q == WC_W'(N_DEV - 1));
  assign frame_shift = (state_q == ST_CLK_HIGH) && tmr_zero;
  assign ret_sample  = (state_q == ST_CLK_LOW) && tmr_zero;
  assign rb_publish  = (state_q == ST_LOAD) && tmr_zero;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE:      if (last_word) state_nx = ST_SEL_SETUP;
      ST_SEL_SETUP: if (tmr_zero)  state_nx = ST_CLK_LOW;
      ST_CLK_LOW:   if (tmr_zero)  state_nx = ST_CLK_HIGH;
      ST_CLK_HIGH:  if (tmr_zero)  state_nx = (bits_q == BL_W'(1)) ? ST_TAIL : ST_CLK_LOW;
      ST_TAIL:      if (tmr_zero)  state_nx = ST_LOAD;
      ST_LOAD:      if (tmr_zero)  state_nx = ST_DONE;
      ST_DONE:                     state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  // Every timed phase is entered with its length minus one in the timer.
  always_comb begin
    tmr_load = (state_nx != state_q);
    unique case (state_nx)
      ST_SEL_SETUP: tmr_val = TMR_W'(CYC_SEL - 1);
      ST_CLK_LOW:   tmr_val = TMR_W'(CYC_LOWPH - 1);
      ST_CLK_HIGH:  tmr_val = TMR_W'(CYC_HIGH - 1);
      ST_TAIL:      tmr_val = TMR_W'(CYC_TAIL - 1);
      ST_LOAD:      tmr_val = TMR_W'(CYC_LOAD - 1);
      default:      tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      bits_q  <= '0;
    end else begin
      state_q <= state_nx;
      if (last_word)    wcnt_q <= '0;
      else if (accept)  wcnt_q <= wcnt_q + 1'b1;
      if (last_word)        bits_q <= BL_W'(FRAME_W);
      else if (frame_shift) bits_q <= bits_q - 1'b1;
    end
  end

  phase_timer #(.CW(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  frame_shreg #(.N_DEV(N_DEV), .CODE_W(CODE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .push(accept), .push_word(in_code),
    .shift(frame_shift), .msb(sdata)
  );

  return_capture #(.FRAME_W(FRAME_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .sample(ret_sample), .bit_in(ret_bit),
    .publish(rb_publish), .rb_data(rb_data)
  );

  assign sclk  = (state_q == ST_CLK_HIGH);
  assign sel_n = (state_q == ST_IDLE) || (state_q == ST_LOAD) || (state_q == ST_DONE);
  assign done  = (state_q == ST_DONE);

  p_ready_drops_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !in_ready);
  p_sel_falls_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> !sclk);
  p_load_after_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (!sclk && !$past(sclk)));
  p_data_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));
  p_no_extra_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (bits_q != '0));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_dac_chain_ctrl.sv
`timescale 1ns/1ps
module test_dac_chain_ctrl;
  localparam int N = 2, W = 12, FW = N * W, P_PS = 5000;

  function automatic int cyc(int ns);
    int c;
    c = (ns * 1000 + P_PS - 1) / P_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int C_SET = (40 * 1000 + P_PS - 1) / P_PS;
  int c_high, c_low, c_sel, c_tail, c_load, c_lowph, t_exp;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_code = '0;
  logic ret_bit, in_ready, sclk, sdata, sel_n, done;
  logic [FW-1:0] rb_data;

  always #2.5 clk = ~clk;

  dac_chain_ctrl #(.N_DEV(N), .CODE_W(W), .CLK_PERIOD_PS(P_PS)) i_dac_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .ret_bit(ret_bit), .sclk(sclk), .sdata(sdata), .sel_n(sel_n), .done(done), .rb_data(rb_data)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural chain: device 0 is nearest the controller.
  logic [W-1:0] dev_sr [N];
  logic [W-1:0] dev_lat[N];
  assign ret_bit = dev_sr[N-1][W-1];

  logic [W-1:0]  words[$];
  logic [FW-1:0] cur_bits = '0, prev_bits = '0;
  bit busy = 0, pend = 0, prev_sclk = 0, prev_sel = 1, prev_sdata = 0, prev_done = 0;
  bit first_rise = 0, seen_frame = 0;
  int acc = 0, tcnt = 0, rise_cnt = 0;
  int low_run = 0, high_run = 0, data_age = 0, sel_low_run = 0, sel_high_run = 0, since_rise = 0;

  initial begin
    c_high = cyc(40); c_low = cyc(40); c_sel = cyc(20); c_tail = cyc(40); c_load = cyc(50);
    c_lowph = (c_low > C_SET) ? c_low : C_SET;
    t_exp = c_sel + FW * (c_lowph + c_high) + c_tail + c_load;
    for (int i = 0; i < N; i++) begin dev_sr[i] = '0; dev_lat[i] = '0; end
  end

  always @(negedge clk) if (rst_n) begin
    chk(in_ready == !busy, "R2", "in_ready vs busy model", in_ready, !busy);
    if (sel_n) chk(!sclk, "R4", "sclk while deselected", sclk, 0);
    if (sclk && prev_sclk) chk(sdata == prev_sdata, "R6", "sdata moved while sclk high", sdata, prev_sdata);

    if (pend) begin tcnt = 0; pend = 0; end else tcnt++;

    if (sclk && !prev_sclk) begin
      chk(data_age >= C_SET, "R6", "setup cycles", data_age, C_SET);
      chk(low_run >= c_low, "R6", "low phase cycles", low_run, c_low);
      if (first_rise) chk(sel_low_run >= c_sel, "R5", "select to first clock", sel_low_run, c_sel);
      first_rise = 0;
      rise_cnt++;
      for (int i = N - 1; i > 0; i--) dev_sr[i] = {dev_sr[i][W-2:0], dev_sr[i-1][W-1]};
      dev_sr[0] = {dev_sr[0][W-2:0], sdata};
    end
    if (!sclk && prev_sclk) chk(high_run == c_high, "R11", "high phase cycles", high_run, c_high);
    if (!sel_n && prev_sel) begin
      chk(!sclk, "R4", "sclk at select fall", sclk, 0);
      if (seen_frame) chk(sel_high_run >= c_load, "R7", "select high width", sel_high_run, c_load);
      first_rise = 1;
    end
    if (sel_n && !prev_sel) begin
      chk(since_rise >= c_tail, "R7", "last clock to load", since_rise, c_tail);
      for (int i = 0; i < N; i++) dev_lat[i] = dev_sr[i];
      seen_frame = 1;
    end

    if (done) begin
      chk(tcnt == t_exp, "R9", "done latency", tcnt, t_exp);
      chk(!prev_done, "R9", "done width", prev_done, 0);
      chk(rise_cnt == FW, "R8", "rising edges per frame", rise_cnt, FW);
      chk(rb_data == prev_bits, "R10", "readback frame", rb_data, prev_bits);
      for (int k = 0; k < N; k++)
        chk(dev_lat[N-1-k] == cur_bits[FW-1-k*W -: W], "R3", "device code",
            dev_lat[N-1-k], cur_bits[FW-1-k*W -: W]);
      prev_bits = cur_bits;
      rise_cnt = 0;
      busy = 0;
    end
    if (in_valid && in_ready) begin
      words.push_back(in_code);
      acc++;
      if (acc == N) begin
        acc = 0; busy = 1; pend = 1;
        for (int k = 0; k < N; k++) cur_bits[FW-1-k*W -: W] = words[k];
        words.delete();
      end
    end

    data_age    = (sdata != prev_sdata) ? 1 : data_age + 1;
    low_run     = sclk ? 0 : low_run + 1;
    high_run    = sclk ? high_run + 1 : 0;
    sel_low_run = sel_n ? 0 : sel_low_run + 1;
    sel_high_run = sel_n ? sel_high_run + 1 : 0;
    since_rise  = (sclk && !prev_sclk) ? 1 : since_rise + 1;
    prev_sclk = sclk; prev_sel = sel_n; prev_sdata = sdata; prev_done = done;
  end

  task automatic send_word(input logic [W-1:0] w, input int gap);
    repeat (gap) @(posedge clk);
    @(posedge clk); #1;
    in_valid = 1'b1; in_code = w;
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    in_valid = 1'b0; in_code = '0;
  endtask

  task automatic wait_done();
    forever begin @(negedge clk); if (done) break; end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sel_n == 1'b1, "R1", "sel_n", sel_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(sdata == 1'b0, "R1", "sdata", sdata, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(rb_data == '0, "R1", "rb_data", rb_data, 0);

    // R3 ordering, back-to-back words
    send_word(12'hABC, 0); send_word(12'h123, 0);
    wait_done();
    // R2 gaps between words, then a held offer while busy must be ignored
    send_word(12'hFFF, 3); send_word(12'h000, 5);
    @(posedge clk); #1; in_valid = 1'b1; in_code = 12'hBAD;
    repeat (40) @(posedge clk);
    #1; in_valid = 1'b0; in_code = '0;
    wait_done();
    send_word(12'h5A5, 1); send_word(12'hA5A, 0);
    wait_done();
    // R10 readback of the previous frame, edge bits set
    send_word(12'h001, 0); send_word(12'h800, 2);
    wait_done();
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule